// File: doc/BRIEF.md
# H-Bridge Current Chopper with Selectable Decay

This block runs one H-bridge of a bipolar stepper drive on a fixed-length PWM period. Each period opens with a drive phase. In that phase the winding is energised along the diagonal that the sign input chooses. An over-current comparator bit then ends the drive phase, but only after a blanking window. From the trip to the end of the period the bridge sits in a decay configuration. That configuration is slow recirculation through both low sides, fast decay through the reversed diagonal, or a mixed form that starts fast and turns slow at a fixed point late in the period.

The analog comparators and the reference DAC live outside the block. The block receives the trip bit, a near-zero-current bit and a flag from the indexer telling it whether the current setpoint is falling. Sign, decay code and the falling flag are taken once, at the start of each period. All four gate enables pass through a per-leg dead-time stage, so the two switches of a leg are never on together and never switch over back to back.

Top module: `hbridge_chopper`

## Requirements
- R1: While `rst_n` is low, all four gate outputs are low. When `en` is low at a clock edge, all four gates are low after that edge and stay low while `en` stays low.
- R2: In the drive phase, `sign`=1 turns on the high side of leg A (output 1) and the low side of leg B (output 2). `sign`=0 turns on the opposite diagonal. `sign` is sampled once, at the start of each period.
- R3: While the period count is below `BLANK_CYC`, `trip` is ignored. The drive phase therefore covers at least period counts 0 to `BLANK_CYC`.
- R4: Once a trip ends the drive phase, the bridge stays in decay until the period ends. The next period starts again with drive.
- R5: Decay code 2'b00 (slow) turns on both low-side gates and neither high side.
- R6: Decay codes 2'b10 and 2'b11 (fast) drive the diagonal opposite to the drive phase. When `zero_det` is seen in fast decay, all four gates go off until the period ends.
- R7: Decay code 2'b01 (mixed) with `decreasing`=1 at period start uses fast decay up to period count `MIX_CYC`-1 and slow decay from count `MIX_CYC` on. A trip seen at count `MIX_CYC`-1 or later goes straight to slow decay.
- R8: Decay code 2'b01 with `decreasing`=0 at period start uses slow decay.
- R9: In each leg, the two gates are never on together. A gate turns on only after both gates of its leg have been off for at least `DEAD_CYC` consecutive cycles.
- R10: The period is `PERIOD_CYC` cycles long. Period count 0 is the cycle after the edge at which `en` is first seen high, and the gates show the drive pattern from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Bridge enable; low forces all gates off and idles the sequencer |
| decay_sel | input | 2 | Decay code: 00 slow, 01 mixed, 10 or 11 fast |
| sign | input | 1 | Current polarity; 1 drives output 1 high relative to output 2 |
| trip | input | 1 | Chopping-threshold comparator result |
| zero_det | input | 1 | Winding current near zero (used in fast decay) |
| decreasing | input | 1 | Indexer setpoint is falling this step |
| gate_hi_a | output | 1 | High-side gate, leg A (output 1) |
| gate_lo_a | output | 1 | Low-side gate, leg A (output 1) |
| gate_hi_b | output | 1 | High-side gate, leg B (output 2) |
| gate_lo_b | output | 1 | Low-side gate, leg B (output 2) |

## Verification
The bench builds the block with a 40-cycle period, a 6-cycle blanking window, the mixed switch-over at count 30 and a 2-cycle dead time. With these values, each period boundary, the blanking edge and the 75% point all fall within a few dozen cycles, and every dead-time gap can be checked cycle by cycle. The small period also makes it cheap to test a trip just before blanking ends, a mixed-mode trip that arrives at the switch-over count, and a sign change that must wait for the next period.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRIVE = 3'd1,
    ST_SLOW  = 3'd2,
    ST_FAST  = 3'd3,
    ST_OFF   = 3'd4
  } chop_st_e;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_cmd_e;

  localparam logic [1:0] DK_SLOW  = 2'b00;
  localparam logic [1:0] DK_MIXED = 2'b01;

  // Requested switch for one leg in a given phase.
  // is_out1 selects leg A (output 1); sign=1 drives output 1 high.
  function automatic leg_cmd_e leg_request(chop_st_e st, logic sign, logic is_out1);
    logic fwd_high;
    fwd_high = (sign == is_out1);
    case (st)
      ST_DRIVE: leg_request = fwd_high ? LEG_HIGH : LEG_LOW;
      ST_FAST:  leg_request = fwd_high ? LEG_LOW  : LEG_HIGH;
      ST_SLOW:  leg_request = LEG_LOW;
      default:  leg_request = LEG_OFF;
    endcase
  endfunction

  // Decay phase entered on a qualified trip.
  function automatic chop_st_e decay_entry(logic [1:0] code, logic falling, logic before_mix);
    if (code == DK_SLOW)       decay_entry = ST_SLOW;
    else if (code == DK_MIXED) decay_entry = (falling && before_mix) ? ST_FAST : ST_SLOW;
    else                       decay_entry = ST_FAST;
  endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int PERIOD_CYC = 2000,
  localparam int CW = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          last
);
  localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD_CYC - 1);

  assign last = (cnt == LAST_CNT);

  // Parked on the last count while idle so the next edge opens a period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= LAST_CNT;
    else if (!en)  cnt <= LAST_CNT;
    else if (last) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 375,
  parameter int MIX_CYC    = 1500,
  localparam int CW = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic          last,
  input  logic [1:0]    decay_sel,
  input  logic          sign,
  input  logic          trip,
  input  logic          zero_det,
  input  logic          decreasing,
  output chop_st_e      st,
  output logic          sign_q,
  output logic          mixed_q
);
  logic [1:0] mode_q;
  logic       falling_q;
  chop_st_e   st_nxt;

  wire blank_done = (cnt >= CW'(BLANK_CYC));
  wire before_mix = (cnt <  CW'(MIX_CYC - 1));
  wire at_mix     = (cnt == CW'(MIX_CYC - 1));
  wire new_period = en && last;

  assign mixed_q = (mode_q == DK_MIXED);

  always_comb begin
    st_nxt = st;
    if (!en)             st_nxt = ST_IDLE;
    else if (last)       st_nxt = ST_DRIVE;
    else begin
      case (st)
        ST_DRIVE: if (trip && blank_done)
                    st_nxt = decay_entry(mode_q, falling_q, before_mix);
        ST_FAST:  if (zero_det)               st_nxt = ST_OFF;
                  else if (mixed_q && at_mix) st_nxt = ST_SLOW;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sign_q    <= 1'b0;
      mode_q    <= DK_SLOW;
      falling_q <= 1'b0;
    end else begin
      st <= st_nxt;
      if (new_period) begin
        sign_q    <= sign;
        mode_q    <= decay_sel;
        falling_q <= decreasing;
      end
    end
  end
endmodule

// File: rtl/leg_deadtime.sv
module leg_deadtime
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 40,
  localparam int DW = $clog2(DEAD_CYC + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  leg_cmd_e req,
  output logic     hi_g,
  output logic     lo_g
);
  logic [DW-1:0] off_cnt;
  wire ready  = (off_cnt >= DW'(DEAD_CYC - 1));
  wire hi_nxt = en && (req == LEG_HIGH) && (hi_g || (!lo_g && ready));
  wire lo_nxt = en && (req == LEG_LOW)  && (lo_g || (!hi_g && ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_g    <= 1'b0;
      lo_g    <= 1'b0;
      off_cnt <= '0;
    end else begin
      hi_g <= hi_nxt;
      lo_g <= lo_nxt;
      if (hi_g || lo_g) off_cnt <= '0;
      else if (!ready)  off_cnt <= off_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 375,
  parameter int MIX_CYC    = 1500,
  parameter int DEAD_CYC   = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] decay_sel,
  input  logic       sign,
  input  logic       trip,
  input  logic       zero_det,
  input  logic       decreasing,
  output logic       gate_hi_a,
  output logic       gate_lo_a,
  output logic       gate_hi_b,
  output logic       gate_lo_b
);
  localparam int CW   = $clog2(PERIOD_CYC);
  localparam int LEGS = 2;

  logic [CW-1:0] cnt;
  logic          last;
  chop_st_e      st;
  logic          sign_q;
  logic          mixed_q;
  logic [LEGS-1:0] hi_v, lo_v;

  chop_timer #(.PERIOD_CYC(PERIOD_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .last(last)
  );

  chop_fsm #(
    .PERIOD_CYC(PERIOD_CYC), .BLANK_CYC(BLANK_CYC), .MIX_CYC(MIX_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .last(last),
    .decay_sel(decay_sel), .sign(sign), .trip(trip), .zero_det(zero_det),
    .decreasing(decreasing), .st(st), .sign_q(sign_q), .mixed_q(mixed_q)
  );

  // Leg 0 is output 1 (leg A), leg 1 is output 2 (leg B).
  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    leg_cmd_e req;
    assign req = leg_request(st, sign_q, 1'(g == 0));
    leg_deadtime #(.DEAD_CYC(DEAD_CYC)) leg_i (
      .clk(clk), .rst_n(rst_n), .en(en), .req(req),
      .hi_g(hi_v[g]), .lo_g(lo_v[g])
    );
  end

  assign gate_hi_a = hi_v[0];
  assign gate_lo_a = lo_v[0];
  assign gate_hi_b = hi_v[1];
  assign gate_lo_b = lo_v[1];
endmodule

// File: rtl/hbridge_chopper_chk.sv
module hbridge_chopper_chk
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 375,
  parameter int MIX_CYC    = 1500,
  parameter int DEAD_CYC   = 40,
  localparam int CW = $clog2(PERIOD_CYC),
  localparam int GW = $clog2(DEAD_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          zero_det,
  input logic [CW-1:0] cnt,
  input chop_st_e      st,
  input logic          mixed_q,
  input logic          gate_hi_a,
  input logic          gate_lo_a,
  input logic          gate_hi_b,
  input logic          gate_lo_b
);
  logic [GW-1:0] gap_a, gap_b;
  wire at_end   = (cnt == CW'(PERIOD_CYC - 1));
  wire in_decay = (st == ST_SLOW) || (st == ST_FAST) || (st == ST_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_a <= '0;
      gap_b <= '0;
    end else begin
      if (gate_hi_a || gate_lo_a)       gap_a <= '0;
      else if (gap_a != GW'(DEAD_CYC))  gap_a <= gap_a + 1'b1;
      if (gate_hi_b || gate_lo_b)       gap_b <= '0;
      else if (gap_b != GW'(DEAD_CYC))  gap_b <= gap_b + 1'b1;
    end
  end

  // R9
  no_shoot_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_a && gate_lo_a));
  // R9
  no_shoot_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_b && gate_lo_b));
  // R9
  dead_hi_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi_a) |-> gap_a >= GW'(DEAD_CYC));
  // R9
  dead_lo_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo_a) |-> gap_a >= GW'(DEAD_CYC));
  // R9
  dead_hi_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi_b) |-> gap_b >= GW'(DEAD_CYC));
  // R9
  dead_lo_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo_b) |-> gap_b >= GW'(DEAD_CYC));
  // R1
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b));
  // R3
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRIVE) && en && (cnt < CW'(BLANK_CYC)) |=> st == ST_DRIVE);
  // R4
  decay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_decay && en && !at_end |=> (st == ST_SLOW) || (st == ST_FAST) || (st == ST_OFF));
  // R6
  fast_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAST) && zero_det && en && !at_end |=> st == ST_OFF);
  // R7
  mixed_fast_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAST) && mixed_q |-> cnt < CW'(MIX_CYC));
endmodule

bind hbridge_chopper hbridge_chopper_chk #(
  .PERIOD_CYC(PERIOD_CYC), .BLANK_CYC(BLANK_CYC),
  .MIX_CYC(MIX_CYC), .DEAD_CYC(DEAD_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .zero_det(zero_det), .cnt(cnt),
  .st(st), .mixed_q(mixed_q), .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
  .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
);

// File: tb/hbridge_chopper_tb_top.sv
module hbridge_chopper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_CYC = 40;
  localparam int B_CYC = 6;
  localparam int M_CYC = 30;
  localparam int D_CYC = 2;

  // Gate patterns {hi_a, lo_a, hi_b, lo_b}
  localparam logic [3:0] PAT_POS  = 4'b1001;
  localparam logic [3:0] PAT_NEG  = 4'b0110;
  localparam logic [3:0] PAT_SLOW = 4'b0101;
  localparam logic [3:0] PAT_OFF  = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] decay_sel = 2'b00;
  logic sign = 1'b1, trip = 1'b0, zero_det = 1'b0, decreasing = 1'b0;
  logic gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;

  int n_checks = 0;
  int n_fail = 0;
  int pos = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_chopper #(
    .PERIOD_CYC(P_CYC), .BLANK_CYC(B_CYC), .MIX_CYC(M_CYC), .DEAD_CYC(D_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .decay_sel(decay_sel), .sign(sign),
    .trip(trip), .zero_det(zero_det), .decreasing(decreasing),
    .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
    .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
  );

  // Independent dead-time monitor, sampled at falling edges (R9).
  logic [1:0] prev_hi = '0, prev_lo = '0;
  int off_run [2] = '{0, 0};
  int dt_events = 0, dt_bad = 0;
  always @(negedge clk) begin
    logic [1:0] h, l;
    h = {gate_hi_b, gate_hi_a};
    l = {gate_lo_b, gate_lo_a};
    for (int k = 0; k < 2; k++) begin
      if (h[k] && l[k]) dt_bad++;
      if ((h[k] && !prev_hi[k]) || (l[k] && !prev_lo[k])) begin
        dt_events++;
        if (off_run[k] < D_CYC) dt_bad++;
      end
      if (h[k] || l[k]) off_run[k] = 0;
      else              off_run[k]++;
    end
    prev_hi = h;
    prev_lo = l;
  end

  task automatic check_gates(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at count %0d: gates=%b expected=%b", req, pos - 2, act, exp);
    end
  endtask

  // Move to the k-th falling edge after the enabling edge.
  task automatic wait_neg(int k);
    while (pos < k) begin
      @(negedge clk);
      pos++;
    end
  endtask

  // Gates reflecting the phase of period count c.
  task automatic sample_at(int c);
    wait_neg(c + 2);
  endtask

  // Input stable during period count c.
  task automatic during(int c);
    wait_neg(c + 1);
  endtask

  task automatic fresh_start(logic [1:0] code, logic sgn, logic dec, logic trp);
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    decay_sel = code; sign = sgn; decreasing = dec; trip = trp; zero_det = 1'b0;
    en = 1'b1;
    pos = 0;
  endtask

  task automatic trip_pulse(int c);
    during(c);     trip = 1'b1;
    during(c + 1); trip = 1'b0;
  endtask

  task automatic t_reset();
    check_gates("R1 reset", PAT_OFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_gates("R1 idle while disabled", PAT_OFF);
  endtask

  task automatic t_drive_sign();
    fresh_start(2'b00, 1'b1, 1'b0, 1'b0);
    sample_at(0);  check_gates("R10 drive visible after count 0", PAT_POS);
    sample_at(3);  check_gates("R2 positive drive", PAT_POS);
    during(20);    sign = 1'b0;
    sample_at(30); check_gates("R2 sign held within period", PAT_POS);
    sample_at(39); check_gates("R10 last count of period", PAT_POS);
    sample_at(P_CYC + 5); check_gates("R2 R10 negative drive next period", PAT_NEG);
  endtask

  task automatic t_blanking();
    fresh_start(2'b00, 1'b1, 1'b0, 1'b0);
    trip_pulse(4);
    sample_at(15); check_gates("R3 trip inside blanking ignored", PAT_POS);
    during(20);    trip = 1'b1;
    sample_at(26); check_gates("R5 slow decay after trip", PAT_SLOW);
    trip = 1'b0;
    fresh_start(2'b00, 1'b1, 1'b0, 1'b1);
    sample_at(B_CYC); check_gates("R3 minimum on-time", PAT_POS);
    sample_at(12); check_gates("R5 slow decay after blanking", PAT_SLOW);
    during(20);    trip = 1'b0;
    sample_at(38); check_gates("R4 decay held to period end", PAT_SLOW);
    sample_at(P_CYC + 5); check_gates("R4 drive restarts next period", PAT_POS);
  endtask

  task automatic t_fast();
    fresh_start(2'b10, 1'b1, 1'b0, 1'b0);
    trip_pulse(10);
    sample_at(20); check_gates("R6 fast decay reversed", PAT_NEG);
    during(25);    zero_det = 1'b1;
    during(26);    zero_det = 1'b0;
    sample_at(30); check_gates("R6 all off at zero current", PAT_OFF);
    sample_at(38); check_gates("R6 stays off to period end", PAT_OFF);
    sample_at(P_CYC + 5); check_gates("R4 drive after fast period", PAT_POS);
    fresh_start(2'b11, 1'b0, 1'b0, 1'b0);
    trip_pulse(10);
    sample_at(20); check_gates("R6 code 11 fast, negative sign", PAT_POS);
  endtask

  task automatic t_mixed();
    fresh_start(2'b01, 1'b1, 1'b1, 1'b0);
    trip_pulse(10);
    sample_at(20); check_gates("R7 mixed starts fast", PAT_NEG);
    sample_at(M_CYC - 1); check_gates("R7 still fast before switch point", PAT_NEG);
    sample_at(M_CYC + 5); check_gates("R7 slow after switch point", PAT_SLOW);
    fresh_start(2'b01, 1'b1, 1'b1, 1'b0);
    trip_pulse(M_CYC - 1);
    sample_at(M_CYC);     check_gates("R9 leg A gap first cycle", 4'b0001);
    sample_at(M_CYC + 1); check_gates("R9 leg A gap second cycle", 4'b0001);
    sample_at(M_CYC + 2); check_gates("R7 late trip goes slow", PAT_SLOW);
    fresh_start(2'b01, 1'b1, 1'b0, 1'b0);
    trip_pulse(10);
    sample_at(20); check_gates("R8 mixed with rising setpoint", PAT_SLOW);
  endtask

  task automatic t_disable();
    fresh_start(2'b00, 1'b1, 1'b0, 1'b0);
    sample_at(10); check_gates("R1 running before disable", PAT_POS);
    en = 1'b0;
    @(negedge clk); check_gates("R1 gates off one clock after disable", PAT_OFF);
    repeat (5) @(negedge clk); check_gates("R1 gates stay off", PAT_OFF);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1'b1;
    n_checks++;
    if (dt_bad != 0 || dt_events == 0) begin
      n_fail++;
      $display("FAIL R9 dead-time monitor: violations=%0d events=%0d expected 0 violations", dt_bad, dt_events);
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_drive_sign();
    t_blanking();
    t_fast();
    t_mixed();
    t_disable();
    finish_run();
  end
endmodule